// File: doc/BRIEF.md
# Processor Bus Takeover Sequencer

This block sits on a processor upgrade card and moves control of the system bus, once and for good, from the processor on the main board to the processor on the card. After system reset it lets the original processor run for a fixed number of clocks, then requests the bus. It waits for the grant, leaves a programmable gap, and waits for the current bus cycle to end. It then acknowledges the grant and holds that acknowledge. One clock later it parks the original processor by driving its halt line low, and a programmable number of clocks after that it lets the new processor out of reset.

The new processor's halt line is driven high at all times, so that input never floats. A grant that does not arrive within a set number of clocks raises a sticky error flag. The request stays asserted while the flag is up, so a late grant still completes the handover. All bus lines are active low. The grant, address strobe and data acknowledge inputs pass through a two-stage synchronizer before the control logic sees them.

Top module: `bus_handover_seq`

## Requirements
- R1: While reset is low and on the first clock after it, the outputs are idle: bus_req_n=1, grant_ack_n=1, old_cpu_halt_n=1, new_cpu_reset_n=0, handover_done=0, grant_timeout=0. A reset in the middle of or after a handover returns the outputs to this state.
- R2: bus_req_n stays 1 for BOOT_CYCLES clocks after reset release and goes to 0 on clock BOOT_CYCLES+1.
- R3: grant_ack_n stays 1 until bus_grant_n has been seen at 0.
- R4: With the bus idle, grant_ack_n falls ACK_DELAY+4 clocks after bus_grant_n falls. This is two synchronizer stages, one state change and ACK_DELAY+1 timer clocks.
- R5: grant_ack_n falls only when addr_strobe_n and data_ack_n are both 1 after synchronization. If they return to 1 b clocks after the grant falls, the acknowledge falls at max(ACK_DELAY+4, b+3) clocks.
- R6: Once grant_ack_n is 0 it stays 0 until reset, whatever the inputs do. bus_req_n returns to 1 on the same clock.
- R7: old_cpu_halt_n goes to 0 exactly one clock after grant_ack_n falls and stays 0 until reset.
- R8: new_cpu_reset_n goes to 1, and handover_done to 1, exactly RST_DELAY+1 clocks after old_cpu_halt_n falls. Before that they are 0 and 1'b0.
- R9: new_cpu_halt_n is 1 at every clock.
- R10: If no grant is seen within GRANT_TIMEOUT+1 clocks of the request, grant_timeout goes to 1 on clock BOOT_CYCLES+GRANT_TIMEOUT+2 after reset release. It stays 1 until reset, and bus_req_n stays 0.
- R11: A grant that arrives after the timeout still completes the sequence with the R4 timing, and grant_timeout stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| bus_grant_n | input | 1 | Bus grant from the original processor, active low |
| addr_strobe_n | input | 1 | Bus address strobe, active low |
| data_ack_n | input | 1 | Bus data acknowledge, active low |
| bus_req_n | output | 1 | Bus request to the original processor, active low |
| grant_ack_n | output | 1 | Bus grant acknowledge, active low |
| old_cpu_halt_n | output | 1 | Halt line to the original processor, active low |
| new_cpu_halt_n | output | 1 | Halt line to the new processor, always driven high |
| new_cpu_reset_n | output | 1 | Reset line to the new processor, active low |
| handover_done | output | 1 | High once the new processor is out of reset |
| grant_timeout | output | 1 | Sticky flag: the grant did not arrive in time |

## Verification
A wrong internal state shows up on the request, acknowledge, halt and reset lines within one clock of the faulty transition. The outputs are registered decodes of the next state, so a skipped state moves an edge by whole clocks, and a lost state releases a line that must stay held. The bench fixes the clock on which each edge must appear for several grant arrival times and bus busy lengths. It then checks the edges on the clock before and the clock of each transition. It also changes the inputs after the handover, so that any exit from the final state shows at once as a released acknowledge or halt.

// File: rtl/handover_pkg.sv
`timescale 1ns/1ps
// Package: shared state encoding for the bus takeover sequencer.
// Assumes: state values are used only inside the sequencer.
package handover_pkg;

    typedef enum logic [2:0] {
        ST_BOOT = 3'd0,  // original processor runs; counting down
        ST_REQ  = 3'd1,  // request asserted; waiting for grant
        ST_WAIT = 3'd2,  // grant seen; spacing delay and bus-idle wait
        ST_ACK  = 3'd3,  // acknowledge asserted
        ST_HALT = 3'd4,  // old processor halted; new one still in reset
        ST_RUN  = 3'd5   // new processor released; final state
    } handover_state_t;

endpackage

// File: rtl/handover_sync.sv
`timescale 1ns/1ps
// Module: multi-bit synchronizer, one flop chain per bit.
// Assumes: each bit is an independent level signal; no bus coherence needed.
// Reset loads RESET_VAL into every stage, which is the inactive level.
module handover_sync #(
    parameter int          WIDTH     = 3,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RESET_VAL;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/handover_timer.sv
`timescale 1ns/1ps
// Module: loadable down-counter that parks at zero.
// Assumes: the caller loads a new value on each state entry that needs a delay.
// Reset loads INIT_VAL so the first delay runs straight out of reset.
module handover_timer #(
    parameter int              CW       = 8,
    parameter logic [CW-1:0]   INIT_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);

    logic [CW-1:0] cnt_q;

    // Load on request, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= INIT_VAL;
        else if (load)    cnt_q <= load_val;
        else if (!zero)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R4: an unloaded timer that has expired stays expired.
    assert_timer_parks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

    // R4: an unloaded running timer steps down by exactly one.
    assert_timer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/bus_handover_seq.sv
`timescale 1ns/1ps
// Module: one-shot bus takeover sequencer.
// What it does: request the bus, wait for the grant, space it and wait for
// bus idle, acknowledge for good, halt the old processor, then release the
// new processor from reset.
// Assumes: all bus lines are active low; the inputs are asynchronous to clk;
// rst_n is synchronous and active low.
module bus_handover_seq
    import handover_pkg::*;
#(
    parameter int BOOT_CYCLES   = 64,
    parameter int ACK_DELAY     = 4,
    parameter int RST_DELAY     = 8,
    parameter int GRANT_TIMEOUT = 4096,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_grant_n,
    input  logic addr_strobe_n,
    input  logic data_ack_n,
    output logic bus_req_n,
    output logic grant_ack_n,
    output logic old_cpu_halt_n,
    output logic new_cpu_halt_n,
    output logic new_cpu_reset_n,
    output logic handover_done,
    output logic grant_timeout
);

    localparam int MAX_AB = (BOOT_CYCLES > ACK_DELAY) ? BOOT_CYCLES : ACK_DELAY;
    localparam int MAX_RT = (RST_DELAY > GRANT_TIMEOUT) ? RST_DELAY : GRANT_TIMEOUT;
    localparam int MAXV   = (MAX_AB > MAX_RT) ? MAX_AB : MAX_RT;
    localparam int CW     = $clog2(MAXV + 1);
    localparam logic [CW-1:0] BOOT_LD = CW'(BOOT_CYCLES);
    localparam logic [CW-1:0] ACK_LD  = CW'(ACK_DELAY);
    localparam logic [CW-1:0] RST_LD  = CW'(RST_DELAY);
    localparam logic [CW-1:0] TO_LD   = CW'(GRANT_TIMEOUT);

    handover_state_t state_q, state_d;
    logic [2:0]      sync_q;
    logic            grant_s, idle_s;
    logic            tmr_load, tmr_zero, err_set;
    logic [CW-1:0]   tmr_val;

    handover_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b111)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({bus_grant_n, addr_strobe_n, data_ack_n}),
        .dout  (sync_q)
    );

    assign grant_s = ~sync_q[2];
    assign idle_s  = sync_q[1] & sync_q[0];

    handover_timer #(
        .CW       (CW),
        .INIT_VAL (BOOT_LD)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    // Next-state and timer-load decision for the takeover chain.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        err_set  = 1'b0;
        case (state_q)
            ST_BOOT: if (tmr_zero) begin
                state_d  = ST_REQ;
                tmr_load = 1'b1;
                tmr_val  = TO_LD;
            end
            ST_REQ: if (grant_s) begin
                state_d  = ST_WAIT;
                tmr_load = 1'b1;
                tmr_val  = ACK_LD;
            end else if (tmr_zero) begin
                err_set  = 1'b1;
            end
            ST_WAIT: if (tmr_zero && idle_s) state_d = ST_ACK;
            ST_ACK: begin
                state_d  = ST_HALT;
                tmr_load = 1'b1;
                tmr_val  = RST_LD;
            end
            ST_HALT: if (tmr_zero) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_BOOT;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // Registered output decode from the next state, so outputs never glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_req_n       <= 1'b1;
            grant_ack_n     <= 1'b1;
            old_cpu_halt_n  <= 1'b1;
            new_cpu_reset_n <= 1'b0;
            handover_done   <= 1'b0;
        end else begin
            bus_req_n       <= !(state_d == ST_REQ || state_d == ST_WAIT);
            grant_ack_n     <= !(state_d == ST_ACK || state_d == ST_HALT || state_d == ST_RUN);
            old_cpu_halt_n  <= !(state_d == ST_HALT || state_d == ST_RUN);
            new_cpu_reset_n <= (state_d == ST_RUN);
            handover_done   <= (state_d == ST_RUN);
        end
    end

    // Sticky grant-timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       grant_timeout <= 1'b0;
        else if (err_set) grant_timeout <= 1'b1;
    end

    // The new processor's halt line is always driven, never floating.
    assign new_cpu_halt_n = 1'b1;

    // R3: the acknowledge only falls after a grant was synchronized.
    assert_ack_after_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_ack_n) |-> $past(state_q == ST_WAIT));

    // R5: the acknowledge only falls when the bus was seen idle.
    assert_ack_on_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(grant_ack_n) |-> $past(idle_s));

    // R6: acknowledge held once given.
    assert_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_ack_n |=> !grant_ack_n);

    // R6: request withdrawn while acknowledge is driven.
    assert_req_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_ack_n |-> bus_req_n);

    // R7: old processor halt only with acknowledge, and held.
    assert_halt_needs_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !old_cpu_halt_n |-> !grant_ack_n);
    assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !old_cpu_halt_n |=> !old_cpu_halt_n);

    // R8: new processor leaves reset only with the old one halted.
    assert_release_after_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        new_cpu_reset_n |-> (!old_cpu_halt_n && handover_done));

    // R10: timeout flag is sticky.
    assert_timeout_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        grant_timeout |=> grant_timeout);

endmodule

// File: tb/bus_handover_seq_bench.sv
`timescale 1ns/1ps
// Bench: vector table of grant timing and bus-busy length, then directed
// tests for reset, timeout, late grant and mid-run reset.
module bus_handover_seq_bench;

    localparam int B = 4;   // BOOT_CYCLES
    localparam int D = 3;   // ACK_DELAY
    localparam int R = 2;   // RST_DELAY
    localparam int T = 20;  // GRANT_TIMEOUT
    localparam int NV = 4;

    // Vector table: wait after request, busy clocks after grant, expected ack clock.
    localparam int VEC_WAIT [NV] = '{0, 5, 2, 10};
    localparam int VEC_BUSY [NV] = '{0, 0, 6, 12};
    localparam int VEC_ACK  [NV] = '{7, 7, 9, 15};

    logic clk = 1'b0;
    logic rst_n, bus_grant_n, addr_strobe_n, data_ack_n;
    logic bus_req_n, grant_ack_n, old_cpu_halt_n, new_cpu_halt_n;
    logic new_cpu_reset_n, handover_done, grant_timeout;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    bus_handover_seq #(
        .BOOT_CYCLES(B), .ACK_DELAY(D), .RST_DELAY(R),
        .GRANT_TIMEOUT(T), .SYNC_STAGES(2)
    ) u_bus_handover_seq (
        .clk(clk), .rst_n(rst_n), .bus_grant_n(bus_grant_n),
        .addr_strobe_n(addr_strobe_n), .data_ack_n(data_ack_n),
        .bus_req_n(bus_req_n), .grant_ack_n(grant_ack_n),
        .old_cpu_halt_n(old_cpu_halt_n), .new_cpu_halt_n(new_cpu_halt_n),
        .new_cpu_reset_n(new_cpu_reset_n), .handover_done(handover_done),
        .grant_timeout(grant_timeout)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_outputs(input string tag);
        chk({tag, " req"},  bus_req_n, 1);
        chk({tag, " ack"},  grant_ack_n, 1);
        chk({tag, " halt"}, old_cpu_halt_n, 1);
        chk({tag, " nrst"}, new_cpu_reset_n, 0);
        chk({tag, " done"}, handover_done, 0);
        chk({tag, " err"},  grant_timeout, 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_grant_n = 1'b1; addr_strobe_n = 1'b1; data_ack_n = 1'b1;
        tick(3);
        idle_outputs("R1 in reset");
        chk("R9 nhalt in reset", new_cpu_halt_n, 1);
        rst_n = 1'b1;
    endtask

    // Drop the grant at the current negedge and check the full sequence.
    task automatic run_grant(input int busy, input int exp_ack, input int exp_err);
        bus_grant_n = 1'b0;
        if (busy > 0) begin addr_strobe_n = 1'b0; data_ack_n = 1'b0; end
        for (int k = 1; k <= exp_ack + R + 2; k++) begin
            tick(1);
            chk("R9 nhalt", new_cpu_halt_n, 1);
            chk("R11 err level", grant_timeout, exp_err);
            if (k == exp_ack - 1) begin
                chk("R5 ack early", grant_ack_n, 1);
                chk("R4 req held", bus_req_n, 0);
            end
            if (k == exp_ack) begin
                chk("R4 ack edge", grant_ack_n, 0);
                chk("R6 req off", bus_req_n, 1);
                chk("R7 halt not yet", old_cpu_halt_n, 1);
            end
            if (k == exp_ack + 1) begin
                chk("R7 halt edge", old_cpu_halt_n, 0);
                chk("R8 still reset", new_cpu_reset_n, 0);
            end
            if (k == exp_ack + R + 1) chk("R8 done early", handover_done, 0);
            if (k == exp_ack + R + 2) begin
                chk("R8 nrst edge", new_cpu_reset_n, 1);
                chk("R8 done edge", handover_done, 1);
            end
            if (k == busy) begin addr_strobe_n = 1'b1; data_ack_n = 1'b1; end
        end
    endtask

    initial begin
        rst_n = 1'b0; bus_grant_n = 1'b1; addr_strobe_n = 1'b1; data_ack_n = 1'b1;

        // Table walk: R2..R9 under several grant and busy patterns.
        for (int v = 0; v < NV; v++) begin
            do_reset();
            tick(1);
            idle_outputs("R1 first clock");
            tick(B - 1);
            chk("R2 req before", bus_req_n, 1);
            tick(1);
            chk("R2 req edge", bus_req_n, 0);
            tick(VEC_WAIT[v]);
            chk("R3 no ack without grant", grant_ack_n, 1);
            run_grant(VEC_BUSY[v], VEC_ACK[v], 0);
            // R6/R7: inputs wiggle after handover, outputs hold.
            bus_grant_n = 1'b1; addr_strobe_n = 1'b0; data_ack_n = 1'b0;
            tick(6);
            chk("R6 ack permanent", grant_ack_n, 0);
            chk("R7 halt permanent", old_cpu_halt_n, 0);
            chk("R8 done permanent", handover_done, 1);
        end

        // R1: reset after completion returns to idle.
        @(negedge clk);
        rst_n = 1'b0;
        tick(2);
        idle_outputs("R1 mid reset");

        // R10: no grant, timeout flag rises and sticks.
        do_reset();
        tick(B + 1 + T);
        chk("R10 err before", grant_timeout, 0);
        tick(1);
        chk("R10 err edge", grant_timeout, 1);
        chk("R10 req held", bus_req_n, 0);
        tick(5);
        chk("R10 err sticky", grant_timeout, 1);
        chk("R10 no ack", grant_ack_n, 1);

        // R11: late grant completes with normal timing, flag remains.
        run_grant(0, D + 4, 1);

        // R1: reset in the middle of a handover.
        do_reset();
        tick(B + 1);
        bus_grant_n = 1'b0;
        tick(D + 5);
        chk("R7 mid halt", old_cpu_halt_n, 0);
        rst_n = 1'b0;
        tick(2);
        idle_outputs("R1 reset mid sequence");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule